// File: doc/BRIEF.md
# Peripheral Protection Configuration Bank

This block is the register bank that sets up ten peripheral protection controllers: two internal APB controllers, four APB expansion controllers and four AHB expansion controllers. For every port of every controller it stores three flags. The first marks the port as non-secure. The second is the privilege setting used while the port is secure. The third is the privilege setting used while the port is non-secure. From these flags it drives a per-port nonsec line and a per-port access-permission line into the protection gates.

The bank also holds two configuration values: a one-bit secure-response setting and a two-bit non-secure-callable setting. It keeps the controllers' interrupt enables and captures their interrupt status levels. It produces one enable line and one clear line per controller.

Software reaches the bank through one 4 KB address space on a valid/ready request port. A window-select input picks between two views. The secure view exposes everything. The non-secure view exposes only the non-secure privilege registers. Requests are always accepted at once, and the response comes one cycle after the request.

Top module: `ppc_cfg_bank`

## Requirements
- R1: After reset, every nonsec, access-permission, enable and clear output is 0, both configuration outputs are 0, and every stored register reads 0.
- R2: A port's access-permission output equals its non-secure privilege bit when its nonsec bit is 1, and its secure privilege bit when its nonsec bit is 0. It follows any change to the three registers one cycle after the write.
- R3: Controller slots are numbered as follows: 0 and 1 are the internal APB controllers, 2+i is APB expansion controller i, and 6+i is AHB expansion controller i. In the secure view, address bits [3:2] pick i within a 16-byte group. The nonsec register groups are 0x70 (internal, i<2), 0x80 (APB expansion) and 0x60 (AHB expansion). The secure privilege groups are 0xB0, 0xC0 and 0xA0 in the same order. Each nonsec output mirrors its stored bit.
- R4: Written values are cut to the port count of the target controller. Bits above that count, and the unused internal slot index 2–3 at 0x78/0x7C, read 0.
- R5: In the non-secure view, only 0xB0–0xB4, 0xC0–0xCC and 0xA0–0xAC respond, holding the non-secure privilege registers. Every other offset in that view reads 0 and ignores writes.
- R6: Size code 0 is a byte, 1 a halfword and 2 a word. Writes take effect only at size 2 with address bits [1:0] equal to 0. A byte or halfword read returns the addressed lane of the word, zero-extended.
- R7: The enable register at 0x28 keeps only bits 0, 1, 4–7 and 20–23. Slot s owns bit s for s<2, bit 4+(s−2) for the APB expansion slots, and bit 20+(s−6) for the AHB expansion slots. Each enable output follows its own bit.
- R8: The status register at 0x20 is read-only. It shows each slot's status input, captured once per cycle, at that slot's bit position.
- R9: A word write to 0x24 drives each clear output high for exactly one cycle, copying the slot's captured status bit; the written data is ignored. Reading 0x24 returns 0.
- R10: 0x10 holds one bit that drives the secure-response output. 0x14 holds two bits that drive the non-secure-callable output.
- R11: Ready is always high. Each request produces a response valid one cycle later. Undefined offsets, including 0x50 and 0x90, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready, always 1 |
| req_ns_i | input | 1 | 1 selects the non-secure view |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 12 | Byte offset within the 4 KB space |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_rdata_o | output | 32 | Read data, 0 for writes |
| irq_stat_i | input | 10 | Interrupt status level per slot |
| nonsec_o | output | 10*SLOT_W | Per-port nonsec, slot s at [s*SLOT_W +: SLOT_W] |
| ap_o | output | 10*SLOT_W | Per-port access permission, same layout |
| irq_en_o | output | 10 | Interrupt enable per slot |
| irq_clr_o | output | 10 | One-cycle clear pulse per slot |
| sec_resp_o | output | 1 | Secure-response configuration |
| nsc_cfg_o | output | 2 | Non-secure-callable configuration |

## Verification
The bench builds the bank with five ports on internal controller 0, one port on internal controller 1, and twelve ports on every expansion controller. This gives a 12-bit slot width. These values make the port-count masking visible three ways: a narrow mask, a single-bit mask, and a mask below the slot width. A mixed nonsec pattern is then applied to one slot to show the per-port selection between the two privilege registers. Lane extraction is checked on non-zero bytes in the middle of a word.

// File: rtl/ppc_cfg_pkg.sv
package ppc_cfg_pkg;
  localparam int N_INT      = 2;
  localparam int N_EXP      = 4;
  localparam int N_SLOTS    = N_INT + 2 * N_EXP;
  localparam int SLOT_IDX_W = $clog2(N_SLOTS);
  localparam int APBE_BASE  = N_INT;
  localparam int AHBE_BASE  = N_INT + N_EXP;

  localparam logic [7:0] GRP_CFG     = 8'h01;
  localparam logic [7:0] GRP_IRQ     = 8'h02;
  localparam logic [7:0] GRP_AHBE_NS = 8'h06;
  localparam logic [7:0] GRP_INT_NS  = 8'h07;
  localparam logic [7:0] GRP_APBE_NS = 8'h08;
  localparam logic [7:0] GRP_AHBE_PR = 8'h0A;
  localparam logic [7:0] GRP_INT_PR  = 8'h0B;
  localparam logic [7:0] GRP_APBE_PR = 8'h0C;

  typedef enum logic [3:0] {
    F_NONE, F_RESP, F_NSC, F_STAT, F_CLR, F_EN, F_NS, F_SP, F_NSP
  } fld_e;

  typedef struct packed {
    fld_e                  fld;
    logic [SLOT_IDX_W-1:0] slot;
  } sel_t;

  // interrupt bit owned by a slot
  function automatic int irq_pos(int s);
    if (s < N_INT) return s;
    else if (s < AHBE_BASE) return 4 + s - APBE_BASE;
    else return 20 + s - AHBE_BASE;
  endfunction

  function automatic logic [31:0] irq_mask();
    logic [31:0] m;
    m = '0;
    for (int s = 0; s < N_SLOTS; s++) m[irq_pos(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ppc_addr_decode.sv
module ppc_addr_decode
  import ppc_cfg_pkg::*;
(
  input  logic       ns_win_i,
  input  logic [9:0] word_addr_i,
  output sel_t       sel_o
);
  logic [7:0] grp;
  logic [1:0] idx;

  assign grp = word_addr_i[9:2];
  assign idx = word_addr_i[1:0];

  always_comb begin
    sel_o.fld  = F_NONE;
    sel_o.slot = '0;
    case (grp)
      GRP_AHBE_PR: begin
        sel_o.fld  = ns_win_i ? F_NSP : F_SP;
        sel_o.slot = SLOT_IDX_W'(AHBE_BASE) + SLOT_IDX_W'(idx);
      end
      GRP_INT_PR: if (int'(idx) < N_INT) begin
        sel_o.fld  = ns_win_i ? F_NSP : F_SP;
        sel_o.slot = SLOT_IDX_W'(idx);
      end
      GRP_APBE_PR: begin
        sel_o.fld  = ns_win_i ? F_NSP : F_SP;
        sel_o.slot = SLOT_IDX_W'(APBE_BASE) + SLOT_IDX_W'(idx);
      end
      default: ;
    endcase
    if (!ns_win_i) begin
      case (grp)
        GRP_CFG: begin
          if (idx == 2'd0) sel_o.fld = F_RESP;
          if (idx == 2'd1) sel_o.fld = F_NSC;
        end
        GRP_IRQ: begin
          if (idx == 2'd0) sel_o.fld = F_STAT;
          if (idx == 2'd1) sel_o.fld = F_CLR;
          if (idx == 2'd2) sel_o.fld = F_EN;
        end
        GRP_AHBE_NS: begin
          sel_o.fld  = F_NS;
          sel_o.slot = SLOT_IDX_W'(AHBE_BASE) + SLOT_IDX_W'(idx);
        end
        GRP_INT_NS: if (int'(idx) < N_INT) begin
          sel_o.fld  = F_NS;
          sel_o.slot = SLOT_IDX_W'(idx);
        end
        GRP_APBE_NS: begin
          sel_o.fld  = F_NS;
          sel_o.slot = SLOT_IDX_W'(APBE_BASE) + SLOT_IDX_W'(idx);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ppc_port_slot.sv
module ppc_port_slot #(
  parameter int PORTS  = 16,
  parameter int SLOT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ns_i,
  input  logic              wr_sp_i,
  input  logic              wr_nsp_i,
  input  logic [SLOT_W-1:0] wdata_i,
  output logic [SLOT_W-1:0] ns_o,
  output logic [SLOT_W-1:0] sp_o,
  output logic [SLOT_W-1:0] nsp_o,
  output logic [SLOT_W-1:0] ap_o
);
  localparam logic [SLOT_W-1:0] MASK = SLOT_W'((64'd1 << PORTS) - 64'd1);

  logic [SLOT_W-1:0] ns_q, sp_q, nsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q  <= '0;
      sp_q  <= '0;
      nsp_q <= '0;
    end else begin
      if (wr_ns_i)  ns_q  <= wdata_i & MASK;
      if (wr_sp_i)  sp_q  <= wdata_i & MASK;
      if (wr_nsp_i) nsp_q <= wdata_i & MASK;
    end
  end

  for (genvar p = 0; p < SLOT_W; p++) begin : g_port
    if (p < PORTS) begin : g_live
      assign ap_o[p] = ns_q[p] ? nsp_q[p] : sp_q[p];
    end else begin : g_tie
      assign ap_o[p] = 1'b0;
    end
  end

  assign ns_o  = ns_q;
  assign sp_o  = sp_q;
  assign nsp_o = nsp_q;

  // R3: stored nonsec equals masked write data
  a_r3_ns_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ns_i |=> ns_o == ($past(wdata_i) & MASK));
  a_r3_ns_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ns_i |=> $stable(ns_o));
  // R2: secure ports follow a fresh secure privilege write
  a_r2_ap_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sp_i && !wr_ns_i && !wr_nsp_i) |=>
      (((ap_o ^ $past(wdata_i)) & ~ns_o & MASK) == '0));
  // R2: non-secure ports follow a fresh non-secure privilege write
  a_r2_ap_nsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_nsp_i && !wr_ns_i && !wr_sp_i) |=>
      (((ap_o ^ $past(wdata_i)) & ns_o & MASK) == '0));
  // R4: nothing above the port count
  a_r4_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ap_o | sp_o | nsp_o) & ~MASK) == '0);
endmodule

// File: rtl/ppc_irq_ctrl.sv
module ppc_irq_ctrl
  import ppc_cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_clr_i,
  input  logic [31:0]        wdata_i,
  input  logic [N_SLOTS-1:0] stat_i,
  output logic [31:0]        en_word_o,
  output logic [31:0]        stat_word_o,
  output logic [N_SLOTS-1:0] en_o,
  output logic [N_SLOTS-1:0] clr_o
);
  localparam logic [31:0] MASK = irq_mask();

  logic [31:0]        en_q;
  logic [N_SLOTS-1:0] stat_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stat_q <= '0;
      clr_q  <= '0;
    end else begin
      if (wr_en_i) en_q <= wdata_i & MASK;
      stat_q <= stat_i;
      clr_q  <= wr_clr_i ? stat_q : '0;
    end
  end

  always_comb begin
    stat_word_o = '0;
    for (int s = 0; s < N_SLOTS; s++) stat_word_o[irq_pos(s)] = stat_q[s];
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_en
    assign en_o[s] = en_q[irq_pos(s)];
  end

  assign en_word_o = en_q;
  assign clr_o     = clr_q;

  // R9: one-cycle clear pulse carrying captured status
  a_r9_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> clr_o == $past(stat_q));
  a_r9_clr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_clr_i |=> clr_o == '0);
  // R7: enable word keeps only owned bits and holds without a write
  a_r7_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> en_word_o == ($past(wdata_i) & MASK));
  a_r7_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_o));
  // R8: status captured one cycle after the input
  a_r8_stat_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(stat_word_o) == $countones($past(stat_i)));
endmodule

// File: rtl/ppc_cfg_bank.sv
module ppc_cfg_bank
  import ppc_cfg_pkg::*;
#(
  parameter int INT0_PORTS = 16,
  parameter int INT1_PORTS = 16,
  parameter int EXP_PORTS  = 16,
  localparam int SLOT_W = (INT0_PORTS > INT1_PORTS)
      ? ((INT0_PORTS > EXP_PORTS) ? INT0_PORTS : EXP_PORTS)
      : ((INT1_PORTS > EXP_PORTS) ? INT1_PORTS : EXP_PORTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_ns_i,
  input  logic                      req_write_i,
  input  logic [11:0]               req_addr_i,
  input  logic [1:0]                req_size_i,
  input  logic [31:0]               req_wdata_i,
  output logic                      rsp_valid_o,
  output logic [31:0]               rsp_rdata_o,
  input  logic [N_SLOTS-1:0]        irq_stat_i,
  output logic [N_SLOTS*SLOT_W-1:0] nonsec_o,
  output logic [N_SLOTS*SLOT_W-1:0] ap_o,
  output logic [N_SLOTS-1:0]        irq_en_o,
  output logic [N_SLOTS-1:0]        irq_clr_o,
  output logic                      sec_resp_o,
  output logic [1:0]                nsc_cfg_o
);
  sel_t              sel;
  logic              wr_ok;
  logic [SLOT_W-1:0] ns_a  [N_SLOTS];
  logic [SLOT_W-1:0] sp_a  [N_SLOTS];
  logic [SLOT_W-1:0] nsp_a [N_SLOTS];
  logic [N_SLOTS-1:0] wr_ns, wr_sp, wr_nsp;
  logic [31:0]       en_word, stat_word, rd_word, rd_shift, rd_lane;
  logic              resp_q, rsp_valid_q;
  logic [1:0]        nsc_q;
  logic [31:0]       rdata_q;

  assign req_ready_o = 1'b1;
  assign wr_ok = req_valid_i && req_write_i && (req_size_i == 2'd2)
                 && (req_addr_i[1:0] == 2'b00);

  ppc_addr_decode u_dec (
    .ns_win_i    (req_ns_i),
    .word_addr_i (req_addr_i[11:2]),
    .sel_o       (sel)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    localparam int P = (s == 0) ? INT0_PORTS : ((s == 1) ? INT1_PORTS : EXP_PORTS);
    logic hit;
    assign hit       = wr_ok && (sel.slot == SLOT_IDX_W'(s));
    assign wr_ns[s]  = hit && (sel.fld == F_NS);
    assign wr_sp[s]  = hit && (sel.fld == F_SP);
    assign wr_nsp[s] = hit && (sel.fld == F_NSP);

    ppc_port_slot #(.PORTS(P), .SLOT_W(SLOT_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_ns_i  (wr_ns[s]),
      .wr_sp_i  (wr_sp[s]),
      .wr_nsp_i (wr_nsp[s]),
      .wdata_i  (req_wdata_i[SLOT_W-1:0]),
      .ns_o     (ns_a[s]),
      .sp_o     (sp_a[s]),
      .nsp_o    (nsp_a[s]),
      .ap_o     (ap_o[s*SLOT_W +: SLOT_W])
    );
    assign nonsec_o[s*SLOT_W +: SLOT_W] = ns_a[s];
  end

  ppc_irq_ctrl u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_ok && sel.fld == F_EN),
    .wr_clr_i    (wr_ok && sel.fld == F_CLR),
    .wdata_i     (req_wdata_i),
    .stat_i      (irq_stat_i),
    .en_word_o   (en_word),
    .stat_word_o (stat_word),
    .en_o        (irq_en_o),
    .clr_o       (irq_clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= 1'b0;
      nsc_q  <= '0;
    end else begin
      if (wr_ok && sel.fld == F_RESP) resp_q <= req_wdata_i[0];
      if (wr_ok && sel.fld == F_NSC)  nsc_q  <= req_wdata_i[1:0];
    end
  end
  assign sec_resp_o = resp_q;
  assign nsc_cfg_o  = nsc_q;

  always_comb begin
    case (sel.fld)
      F_RESP:  rd_word = {31'd0, resp_q};
      F_NSC:   rd_word = {30'd0, nsc_q};
      F_STAT:  rd_word = stat_word;
      F_EN:    rd_word = en_word;
      F_NS:    rd_word = 32'(ns_a[sel.slot]);
      F_SP:    rd_word = 32'(sp_a[sel.slot]);
      F_NSP:   rd_word = 32'(nsp_a[sel.slot]);
      default: rd_word = '0;
    endcase
  end

  assign rd_shift = rd_word >> {req_addr_i[1:0], 3'b000};
  always_comb begin
    case (req_size_i)
      2'd0:    rd_lane = {24'd0, rd_shift[7:0]};
      2'd1:    rd_lane = {16'd0, rd_shift[15:0]};
      default: rd_lane = rd_shift;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rdata_q     <= (req_valid_i && !req_write_i) ? rd_lane : '0;
    end
  end
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;

  // R11: response follows every request one cycle later
  a_r11_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R6: narrow writes leave every output unchanged
  a_r6_narrow_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_size_i != 2'd2) |=>
      ($stable(nonsec_o) && $stable(ap_o) && $stable(irq_en_o)
       && $stable(sec_resp_o) && $stable(nsc_cfg_o)));
  // R5: the non-secure view cannot touch nonsec, enables or config
  a_r5_ns_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_ns_i) |=>
      ($stable(nonsec_o) && $stable(irq_en_o) && $stable(sec_resp_o)
       && $stable(nsc_cfg_o)));
  // R10: config outputs only move on a word write
  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok |=> ($stable(sec_resp_o) && $stable(nsc_cfg_o)));
endmodule

// File: tb/ppc_cfg_bank_tb_top.sv
module ppc_cfg_bank_tb_top;
  localparam int SW = 12;
  localparam int NS = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ns_i = 1'b0, req_write_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [1:0]  req_size_i = 2'd2;
  logic [31:0] req_wdata_i = '0;
  logic req_ready_o, rsp_valid_o, sec_resp_o;
  logic [31:0] rsp_rdata_o;
  logic [NS-1:0] irq_stat_i = '0, irq_en_o, irq_clr_o;
  logic [NS*SW-1:0] nonsec_o, ap_o;
  logic [1:0] nsc_cfg_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ppc_cfg_bank #(.INT0_PORTS(5), .INT1_PORTS(1), .EXP_PORTS(12)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_ns_i, .req_write_i,
    .req_addr_i, .req_size_i, .req_wdata_i, .rsp_valid_o, .rsp_rdata_o,
    .irq_stat_i, .nonsec_o, .ap_o, .irq_en_o, .irq_clr_o, .sec_resp_o,
    .nsc_cfg_o
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ns_of(int s);
    return 32'(nonsec_o[s*SW +: SW]);
  endfunction
  function automatic logic [31:0] ap_of(int s);
    return 32'(ap_o[s*SW +: SW]);
  endfunction

  task automatic wr(bit nsw, logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_ns_i = nsw;
    req_addr_i = a; req_wdata_i = d; req_size_i = sz;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic rd(bit nsw, logic [11:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_ns_i = nsw;
    req_addr_i = a; req_size_i = sz;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    d = rsp_rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 nonsec", 32'(nonsec_o != '0), 0);
    check("R1 ap", 32'(ap_o != '0), 0);
    check("R1 en/clr", {22'd0, irq_en_o | irq_clr_o}, 0);
    check("R1 cfg", {29'd0, nsc_cfg_o, sec_resp_o}, 0);
    rd(0, 12'h0C4, d); check("R1 read sp", d, 0);
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(0, 12'h0C4, 32'hABC);
    wr(0, 12'h084, 32'h0F0);
    wr(1, 12'h0C4, 32'h00F);
    check("R3 nonsec slot3", ns_of(3), 32'h0F0);
    check("R2 ap mixed", ap_of(3), 32'hA0C);
    wr(1, 12'h0C4, 32'h0F0);
    check("R2 ap after nsp", ap_of(3), 32'hAFC);
    rd(0, 12'h084, d); check("R3 read ns", d, 32'h0F0);
    rd(0, 12'h0C4, d); check("R3 read sp", d, 32'hABC);
    rd(1, 12'h0C4, d); check("R5 read nsp", d, 32'h0F0);
    wr(0, 12'h068, 32'h5);
    check("R3 ahb slot8", ns_of(8), 32'h5);
    check("R3 slot4 untouched", ns_of(4), 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(0, 12'h070, 32'hFFFF_FFFF);
    check("R4 slot0 5 ports", ns_of(0), 32'h1F);
    wr(0, 12'h0B4, 32'hFFFF_FFFF);
    rd(0, 12'h0B4, d); check("R4 slot1 1 port", d, 32'h1);
    wr(0, 12'h080, 32'hFFFF_FFFF);
    rd(0, 12'h080, d); check("R4 slot2 12 ports", d, 32'hFFF);
    wr(0, 12'h078, 32'hFFFF_FFFF);
    rd(0, 12'h078, d); check("R4 unused int index", d, 0);
  endtask

  task automatic t_ns_view();
    logic [31:0] d;
    wr(1, 12'h070, 32'h3);
    check("R5 ns view no nonsec write", ns_of(0), 32'h1F);
    rd(1, 12'h070, d); check("R5 ns view hides nonsec", d, 0);
    wr(1, 12'h010, 32'h1);
    check("R5 ns view no cfg write", {31'd0, sec_resp_o}, 0);
    wr(1, 12'h028, 32'hFFFF_FFFF);
    check("R5 ns view no enable write", {22'd0, irq_en_o}, 0);
  endtask

  task automatic t_narrow();
    logic [31:0] d;
    wr(0, 12'h084, 32'hFFF, 2'd1);
    wr(0, 12'h084, 32'hFFF, 2'd0);
    wr(0, 12'h085, 32'hFFF, 2'd2);
    check("R6 narrow/unaligned ignored", ns_of(3), 32'h0F0);
    rd(0, 12'h0C5, d, 2'd0); check("R6 byte lane", d, 32'h0A);
    rd(0, 12'h0C4, d, 2'd1); check("R6 low half", d, 32'hABC);
    rd(0, 12'h0C6, d, 2'd1); check("R6 high half", d, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(0, 12'h010, 32'hFFFF_FFFF);
    check("R10 resp out", {31'd0, sec_resp_o}, 1);
    rd(0, 12'h010, d); check("R10 resp read", d, 1);
    wr(0, 12'h014, 32'hFF);
    check("R10 nsc out", {30'd0, nsc_cfg_o}, 3);
    rd(0, 12'h014, d); check("R10 nsc read", d, 3);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(0, 12'h028, 32'hFFFF_FFFF);
    rd(0, 12'h028, d); check("R7 enable mask", d, 32'h00F0_00F3);
    check("R7 all enables", {22'd0, irq_en_o}, 32'h3FF);
    wr(0, 12'h028, 32'h0010_0012);
    check("R7 enable mapping", {22'd0, irq_en_o}, 32'h046);
  endtask

  task automatic t_status_clear();
    logic [31:0] d;
    irq_stat_i = 10'b10_0000_1001;
    @(negedge clk_i);
    rd(0, 12'h020, d); check("R8 status layout", d, 32'h0080_0021);
    wr(0, 12'h020, 32'h0);
    rd(0, 12'h020, d); check("R8 status read-only", d, 32'h0080_0021);
    wr(0, 12'h024, 32'h0);
    check("R9 clear pulse", {22'd0, irq_clr_o}, 32'h209);
    @(negedge clk_i);
    check("R9 clear one cycle", {22'd0, irq_clr_o}, 0);
    rd(0, 12'h024, d); check("R9 clear reads 0", d, 0);
    irq_stat_i = 10'b00_0000_0010;
    @(negedge clk_i);
    wr(0, 12'h024, 32'hFFFF_FFFF);
    check("R9 clear follows status", {22'd0, irq_clr_o}, 32'h002);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    check("R11 ready", {31'd0, req_ready_o}, 1);
    wr(0, 12'h050, 32'hFFFF_FFFF);
    wr(0, 12'h090, 32'hFFFF_FFFF);
    rd(0, 12'h050, d); check("R11 0x50 reads 0", d, 0);
    check("R11 rsp valid", {31'd0, rsp_valid_o}, 1);
    rd(1, 12'h090, d); check("R11 0x90 reads 0", d, 0);
    rd(0, 12'h3F0, d); check("R11 undefined reads 0", d, 0);
    @(negedge clk_i);
    check("R11 rsp idle", {31'd0, rsp_valid_o}, 0);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset clears nonsec", 32'(nonsec_o != '0), 0);
    check("R1 reset clears cfg", {29'd0, nsc_cfg_o, sec_resp_o}, 0);
    rd(0, 12'h028, d); check("R1 reset clears enable", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_select();
    t_mask();
    t_ns_view();
    t_narrow();
    t_cfg();
    t_enable();
    t_status_clear();
    t_undef();
    t_reset_again();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule